// File: doc/BRIEF.md
# CPU Idle Power-State Sequencer

This controller sits next to one processor core. It moves that core into and out of a low-power state. Software first selects one of four sleep depths in a small mode register. The core's wait-for-interrupt indication then starts the selected sequence. The controller gates the core clock. Depending on the selected depth, it also:

- requests a reduced retention voltage,
- switches the core supply off and holds the core in warm reset, and
- requests standby of the shared cache hierarchy when the whole cluster is idle.

A wake interrupt ends the wait. The restore steps then run in a fixed order. Power comes back first, with a bounded wait on a power-good input. Next the cache hierarchy must report ready. Only then is the core released.

For the deepest state, the controller also exchanges a four-phase request/acknowledge with a system power manager. It raises the request only when every core of the cluster has chosen that state. Once any sequence completes, the mode register falls back to plain standby.

Top module: `core_idle_seq`

## Requirements
- R1: After reset, status is 0 and mode is 0. clkGate, retVoltReq, coreReset, cacheStbyReq, pmReq, done and pwrErr are all low, and pwrOn is high.
- R2: The mode encodings are 0 standby, 1 retention, 2 core-only power-off and 3 full collapse. A write (modeWrEn with modeWrData) takes effect only in the active state and only when wfiReq is low in the same cycle. Any other write leaves mode unchanged.
- R3: In the active state, wfiReq moves the controller to the sleep state on the next cycle. Sleep keeps clkGate high and lasts until wakeIrq is sampled high.
- R4: cacheStbyReq is high only in the sleep state, and only while clusterIdle is high.
- R5: retVoltReq is high only in the sleep state with mode 1.
- R6: In modes 2 and 3, the sleep and handshake states drive pwrOn low and coreReset high. The power restore state drives pwrOn high.
- R7: Power restore ends when powerGood is sampled high. It also ends, with powerGood still low, on the cycle its counter has reached timeoutLimit, which is after timeoutLimit+1 cycles in the state. A timeout sets pwrErr, which stays set until reset, and the sequence still continues.
- R8: The cache-confirm state holds until cacheReady is sampled high. The next cycle is the release state, with clkGate low, coreReset low and a one-cycle done pulse. The cycle after that is the active state.
- R9: On leaving the release state, mode returns to 0 whatever mode was selected.
- R10: In mode 3, pmReq rises during sleep only while clusterCollapse is high and wakeIrq is low. It stays high until pmAck is sampled high in the handshake state. Power restore begins only after pmAck has then been sampled low. If mode 3 wakes without pmReq raised, the controller goes straight to power restore.
- R11: The status encodings are 0 active, 1 sleep, 2 await-ack, 3 await-ack-release, 4 power restore, 5 cache confirm and 6 release. Standby and retention go from sleep directly to cache confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 2 | Mode value to write |
| wfiReq | input | 1 | Core wait-for-interrupt indication |
| wakeIrq | input | 1 | Wake interrupt |
| clusterIdle | input | 1 | All cores of the cluster idle |
| clusterCollapse | input | 1 | All cores have chosen full collapse |
| powerGood | input | 1 | Core supply is stable |
| cacheReady | input | 1 | Cache hierarchy out of standby and ready |
| pmAck | input | 1 | System power manager acknowledge |
| timeoutLimit | input | CNT_W | Power restore timeout limit in cycles |
| clkGate | output | 1 | Core clock gate enable |
| retVoltReq | output | 1 | Retention voltage request |
| pwrOn | output | 1 | Core power switch enable |
| coreReset | output | 1 | Core warm reset |
| cacheStbyReq | output | 1 | Cache hierarchy standby request |
| pmReq | output | 1 | System power manager request |
| done | output | 1 | One-cycle pulse when the core is released |
| pwrErr | output | 1 | Sticky power-good timeout flag |
| mode | output | 2 | Current mode register |
| status | output | 3 | Current sequencer state |

## Verification
Every cycle, the bench compares each output and the status code against a behavioural model. A wrong state therefore appears on status in the same cycle it is entered. In most cases it also disturbs clkGate, pwrOn or coreReset at once.

A faulty power-restore counter changes the cycle on which cache confirm is entered, or whether pwrErr rises. A slip in the handshake shows up as pmReq high or low one cycle off, or as power restore starting while pmAck is still high. A mode register that is not locked, or not cleared, shows up on the mode output no later than the end of the next sequence.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE  = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_PM_ACK  = 3'd2,
    ST_PM_REL  = 3'd3,
    ST_PWR_UP  = 3'd4,
    ST_CACHE   = 3'd5,
    ST_RELEASE = 3'd6
  } seqState_e;

  typedef enum logic [1:0] {
    MODE_STANDBY  = 2'd0,
    MODE_RETAIN   = 2'd1,
    MODE_SOLO_OFF = 2'd2,
    MODE_FULL_OFF = 2'd3
  } idleMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic modeWr;
    logic modeClr;
    logic cntClr;
    logic cntInc;
    logic errSet;
    logic pmSet;
    logic pmClr;
  } seqStrobe_t;

  // Modes 2 and 3 switch the core supply off
  function automatic logic isPowerOff(idleMode_e m);
    return (m == MODE_SOLO_OFF) || (m == MODE_FULL_OFF);
  endfunction

endpackage

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
  import idle_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wfiReq,
  input  logic       wakeIrq,
  input  logic       modeWrEn,
  input  logic       clusterCollapse,
  input  logic       powerGood,
  input  logic       cacheReady,
  input  logic       pmAck,
  input  idleMode_e  mode,
  input  logic       pmReqQ,
  input  logic       timedOut,
  output seqState_e  state,
  output seqStrobe_t strb
);

  seqState_e nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_ACTIVE: begin
        strb.modeWr = modeWrEn && !wfiReq;
        if (wfiReq) nextState = ST_SLEEP;
      end
      ST_SLEEP: begin
        strb.pmSet = (mode == MODE_FULL_OFF) && clusterCollapse && !wakeIrq;
        if (wakeIrq) begin
          if (isPowerOff(mode)) begin
            if (pmReqQ) begin
              nextState = ST_PM_ACK;
            end else begin
              nextState   = ST_PWR_UP;
              strb.cntClr = 1'b1;
            end
          end else begin
            nextState = ST_CACHE;
          end
        end
      end
      ST_PM_ACK: begin
        if (pmAck) begin
          strb.pmClr = 1'b1;
          nextState  = ST_PM_REL;
        end
      end
      ST_PM_REL: begin
        if (!pmAck) begin
          nextState   = ST_PWR_UP;
          strb.cntClr = 1'b1;
        end
      end
      ST_PWR_UP: begin
        if (powerGood) begin
          nextState = ST_CACHE;
        end else if (timedOut) begin
          strb.errSet = 1'b1;
          nextState   = ST_CACHE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_CACHE: begin
        if (cacheReady) nextState = ST_RELEASE;
      end
      ST_RELEASE: begin
        strb.modeClr = 1'b1;
        nextState    = ST_ACTIVE;
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nextState;
  end

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !wakeIrq) |=> state == ST_SLEEP); // R3
  AST_CACHE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CACHE && !cacheReady) |=> state == ST_CACHE); // R8
  AST_RELEASE_AFTER_CACHE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CACHE && cacheReady) |=> state == ST_RELEASE); // R8
  AST_PM_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PM_REL && pmAck) |=> state == ST_PM_REL); // R10
  AST_PWRUP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PWR_UP && !powerGood && timedOut) |=> state == ST_CACHE); // R7

endmodule

// File: rtl/idle_seq_datapath.sv
module idle_seq_datapath
  import idle_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqState_e        state,
  input  seqStrobe_t       strb,
  input  logic [1:0]       modeWrData,
  input  logic             clusterIdle,
  input  logic [CNT_W-1:0] timeoutLimit,
  output idleMode_e        mode,
  output logic             pmReq,
  output logic             timedOut,
  output logic             pwrErr,
  output logic             clkGate,
  output logic             retVoltReq,
  output logic             pwrOn,
  output logic             coreReset,
  output logic             cacheStbyReq,
  output logic             done
);

  logic [CNT_W-1:0] waitCnt;
  logic             offPhase;
  logic             gatedPhase;

  // Mode register: locked outside the active state, cleared on release
  always_ff @(posedge clk) begin
    if (!rstN)             mode <= MODE_STANDBY;
    else if (strb.modeClr) mode <= MODE_STANDBY;
    else if (strb.modeWr)  mode <= idleMode_e'(modeWrData);
  end

  // Power-good wait counter
  always_ff @(posedge clk) begin
    if (!rstN)            waitCnt <= '0;
    else if (strb.cntClr) waitCnt <= '0;
    else if (strb.cntInc) waitCnt <= waitCnt + 1'b1;
  end
  assign timedOut = (waitCnt >= timeoutLimit);

  // Sticky power error flag
  always_ff @(posedge clk) begin
    if (!rstN)            pwrErr <= 1'b0;
    else if (strb.errSet) pwrErr <= 1'b1;
  end

  // System power manager request
  always_ff @(posedge clk) begin
    if (!rstN)           pmReq <= 1'b0;
    else if (strb.pmClr) pmReq <= 1'b0;
    else if (strb.pmSet) pmReq <= 1'b1;
  end

  // Output decode
  assign offPhase     = (state == ST_SLEEP) || (state == ST_PM_ACK) || (state == ST_PM_REL);
  assign gatedPhase   = offPhase || (state == ST_PWR_UP) || (state == ST_CACHE);
  assign clkGate      = gatedPhase;
  assign retVoltReq   = (state == ST_SLEEP) && (mode == MODE_RETAIN);
  assign pwrOn        = !(offPhase && isPowerOff(mode));
  assign coreReset    = gatedPhase && isPowerOff(mode);
  assign cacheStbyReq = (state == ST_SLEEP) && clusterIdle;
  assign done         = (state == ST_RELEASE);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pwrErr |=> pwrErr); // R7
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_ACTIVE && !strb.modeClr) |=> $stable(mode)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_RESET_WHILE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !pwrOn |-> coreReset); // R6
  AST_PM_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pmReq) |-> (mode == MODE_FULL_OFF)); // R10

endmodule

// File: rtl/core_idle_seq.sv
module core_idle_seq
  import idle_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrEn,
  input  logic [1:0]       modeWrData,
  input  logic             wfiReq,
  input  logic             wakeIrq,
  input  logic             clusterIdle,
  input  logic             clusterCollapse,
  input  logic             powerGood,
  input  logic             cacheReady,
  input  logic             pmAck,
  input  logic [CNT_W-1:0] timeoutLimit,
  output logic             clkGate,
  output logic             retVoltReq,
  output logic             pwrOn,
  output logic             coreReset,
  output logic             cacheStbyReq,
  output logic             pmReq,
  output logic             done,
  output logic             pwrErr,
  output logic [1:0]       mode,
  output logic [2:0]       status
);

  seqState_e  state;
  seqStrobe_t strb;
  idleMode_e  modeQ;
  logic       timedOut;

  idle_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .wakeIrq(wakeIrq),
    .modeWrEn(modeWrEn), .clusterCollapse(clusterCollapse),
    .powerGood(powerGood), .cacheReady(cacheReady), .pmAck(pmAck),
    .mode(modeQ), .pmReqQ(pmReq), .timedOut(timedOut),
    .state(state), .strb(strb)
  );

  idle_seq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .state(state), .strb(strb),
    .modeWrData(modeWrData), .clusterIdle(clusterIdle),
    .timeoutLimit(timeoutLimit), .mode(modeQ), .pmReq(pmReq),
    .timedOut(timedOut), .pwrErr(pwrErr), .clkGate(clkGate),
    .retVoltReq(retVoltReq), .pwrOn(pwrOn), .coreReset(coreReset),
    .cacheStbyReq(cacheStbyReq), .done(done)
  );

  assign mode   = modeQ;
  assign status = state;

  AST_STBY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cacheStbyReq |-> (clusterIdle && clkGate)); // R4

endmodule

// File: tb/core_idle_seq_test.sv
module core_idle_seq_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 0, wfiReq = 0, wakeIrq = 0, clusterIdle = 0;
  logic clusterCollapse = 0, powerGood = 0, cacheReady = 0, pmAck = 0;
  logic [1:0] modeWrData = 0;
  logic [CNT_W-1:0] timeoutLimit = 8'd4;
  logic clkGate, retVoltReq, pwrOn, coreReset, cacheStbyReq, pmReq, done, pwrErr;
  logic [1:0] mode;
  logic [2:0] status;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;
  // reference model state
  int mSt = 0, mMode = 0, mPm = 0, mCnt = 0, mErr = 0;

  always #5 clk = ~clk;

  core_idle_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .wfiReq(wfiReq), .wakeIrq(wakeIrq), .clusterIdle(clusterIdle),
    .clusterCollapse(clusterCollapse), .powerGood(powerGood),
    .cacheReady(cacheReady), .pmAck(pmAck), .timeoutLimit(timeoutLimit),
    .clkGate(clkGate), .retVoltReq(retVoltReq), .pwrOn(pwrOn),
    .coreReset(coreReset), .cacheStbyReq(cacheStbyReq), .pmReq(pmReq),
    .done(done), .pwrErr(pwrErr), .mode(mode), .status(status)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model update
  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mMode = 0; mPm = 0; mCnt = 0; mErr = 0;
    end else begin
      case (mSt)
        0: begin
          if (modeWrEn && !wfiReq) mMode = modeWrData;
          if (wfiReq) mSt = 1;
        end
        1: begin
          if (wakeIrq) begin
            if (mMode >= 2) begin
              if (mPm == 1) mSt = 2;
              else begin mSt = 4; mCnt = 0; end
            end else mSt = 5;
          end else if (mMode == 3 && clusterCollapse) mPm = 1;
        end
        2: if (pmAck) begin mPm = 0; mSt = 3; end
        3: if (!pmAck) begin mSt = 4; mCnt = 0; end
        4: begin
          if (powerGood) mSt = 5;
          else if (mCnt >= timeoutLimit) begin mErr = 1; mSt = 5; end
          else mCnt++;
        end
        5: if (cacheReady) mSt = 6;
        default: begin mSt = 0; mMode = 0; end
      endcase
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R11", "status", status, mSt);
      check("R3", "clkGate", clkGate, (mSt >= 1 && mSt <= 5));
      check("R5", "retVoltReq", retVoltReq, (mSt == 1 && mMode == 1));
      check("R6", "pwrOn", pwrOn, !(mMode >= 2 && mSt >= 1 && mSt <= 3));
      check("R8", "coreReset", coreReset, (mMode >= 2 && mSt >= 1 && mSt <= 5));
      check("R4", "cacheStbyReq", cacheStbyReq, (mSt == 1 && clusterIdle));
      check("R10", "pmReq", pmReq, mPm);
      check("R8", "done", done, (mSt == 6));
      check("R7", "pwrErr", pwrErr, mErr);
      check("R2/R9", "mode", mode, mMode);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic setMode(int m);
    modeWrEn = 1; modeWrData = m[1:0]; cyc(1);
    modeWrEn = 0;
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    check("R1", "status", status, 0);
    check("R1", "mode", mode, 0);
    check("R1", "clkGate", clkGate, 0);
    check("R1", "pwrOn", pwrOn, 1);
    check("R1", "coreReset", coreReset, 0);
    check("R1", "pmReq|done|pwrErr", pmReq | done | pwrErr, 0);
    check("R1", "retVoltReq|cacheStbyReq", retVoltReq | cacheStbyReq, 0);
    #1;

    // Standby with cluster idle toggling, write during sleep ignored (R2)
    wfiReq = 1; cyc(1); wfiReq = 0;
    clusterIdle = 1; cyc(3); clusterIdle = 0; cyc(2);
    modeWrEn = 1; modeWrData = 3; cyc(1); modeWrEn = 0;
    wakeIrq = 1; cyc(1); wakeIrq = 0;
    cyc(3); cacheReady = 1; cyc(3); cacheReady = 0; cyc(2);

    // Write together with wfi is ignored (R2)
    modeWrEn = 1; modeWrData = 2; wfiReq = 1; cyc(1);
    modeWrEn = 0; wfiReq = 0; cyc(2);
    wakeIrq = 1; cacheReady = 1; cyc(1); wakeIrq = 0; cyc(3); cacheReady = 0;

    // Retention
    setMode(1); cyc(1);
    wfiReq = 1; cyc(1); wfiReq = 0; clusterIdle = 1; cyc(4);
    wakeIrq = 1; cyc(1); wakeIrq = 0; clusterIdle = 0;
    cyc(2); cacheReady = 1; cyc(3); cacheReady = 0;

    // Core-only power-off, power good after a few cycles
    setMode(2);
    wfiReq = 1; cyc(1); wfiReq = 0; cyc(3);
    wakeIrq = 1; cyc(1); wakeIrq = 0; cyc(2);
    powerGood = 1; cyc(2); cyc(2); cacheReady = 1; cyc(3);
    cacheReady = 0; powerGood = 0;

    // Core-only power-off with power-good timeout (R7)
    setMode(2);
    wfiReq = 1; cyc(1); wfiReq = 0; cyc(2);
    wakeIrq = 1; cyc(1); wakeIrq = 0; cyc(10);
    cacheReady = 1; cyc(3); cacheReady = 0;

    // Timeout with a zero limit
    timeoutLimit = 0;
    setMode(3);
    wfiReq = 1; cyc(1); wfiReq = 0; cyc(2);
    wakeIrq = 1; cyc(1); wakeIrq = 0; cyc(3);
    cacheReady = 1; cyc(3); cacheReady = 0;
    timeoutLimit = 8'd4;

    // Full collapse with manager handshake (R10)
    setMode(3);
    wfiReq = 1; cyc(1); wfiReq = 0; cyc(2);
    clusterCollapse = 1; cyc(3); pmAck = 1; cyc(2);
    wakeIrq = 1; cyc(1); wakeIrq = 0; clusterCollapse = 0; cyc(3);
    pmAck = 0; cyc(2); powerGood = 1; cyc(2);
    cacheReady = 1; cyc(3); cacheReady = 0; powerGood = 0;

    // Full collapse, ack arrives only after wake
    setMode(3);
    wfiReq = 1; cyc(1); wfiReq = 0;
    clusterCollapse = 1; cyc(2);
    wakeIrq = 1; cyc(1); wakeIrq = 0; clusterCollapse = 0; cyc(3);
    pmAck = 1; cyc(2); pmAck = 0; cyc(1);
    powerGood = 1; cacheReady = 1; cyc(4); powerGood = 0; cacheReady = 0;

    // Full collapse without cluster agreement skips the handshake
    setMode(3);
    wfiReq = 1; cyc(1); wfiReq = 0; cyc(3);
    wakeIrq = 1; cyc(1); wakeIrq = 0;
    powerGood = 1; cacheReady = 1; cyc(5);
    powerGood = 0; cacheReady = 0; cyc(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule